// File: doc/BRIEF.md
# Receive-side flow control and character match unit

This unit sits beside one serial channel, between the receive deserializer and the receive FIFO, and looks at every received character once. A bank of comparators checks each character against a host-set pause character, a host-set resume character, a station address and three general-purpose match characters. When automatic receive-side flow handling is on, a pause character stops the local transmitter and a resume character starts it again. Both characters are then dropped instead of being passed to the FIFO.

In the other direction, the unit watches the receive FIFO fill level. When the FIFO gets close to full, it asks the transmitter to insert a pause character. Once the FIFO has drained, it asks for a resume character. Each request is held until the transmitter reports that it sent the character, and it takes precedence over normal transmit data.

In multidrop mode the unit blocks reception until an address character that carries this channel's address arrives. An address character is one whose address-flag bit (the parity-bit position) is set. The three general-purpose comparators report a match on every received character, whether or not that character is passed on.

Top module: `rxflow_ctl`

## Requirements
- R1: After reset, tx_enable=1, tx_normal_ok=1, ins_req=0, rx_write=0 and gp_hit=0.
- R2: With cfg_auto_rx_flow=1 and the receive gate open, a received data character equal to cfg_xoff_char drives tx_enable to 0 and rx_write stays 0, both in the cycle after rx_valid.
- R3: Under the same conditions, a data character equal to cfg_xon_char drives tx_enable to 1 in the cycle after rx_valid, and rx_write stays 0.
- R4: With cfg_auto_rx_flow=0, tx_enable is 1 from the cycle after the bit goes low, and pause and resume characters are written like any other data.
- R5: With cfg_multidrop=0, every received character that is not consumed as a flow character gives a one-cycle rx_write pulse in the cycle after rx_valid, whatever the value of rx_addr_bit.
- R6: With cfg_multidrop=1, a character with rx_addr_bit=1 and rx_data equal to cfg_chan_addr opens the gate and is itself written. Data characters after it are written.
- R7: With cfg_multidrop=1, a character with rx_addr_bit=1 and any other value closes the gate and is not written. Data characters (rx_addr_bit=0) are not written while the gate is closed, and the gate starts closed.
- R8: gp_hit[i] pulses in the cycle after rx_valid whenever rx_data equals general-purpose character i, which is field i of cfg_gp_chars (bits 8*i+7:8*i). This happens even when the character is dropped or consumed.
- R9: With cfg_auto_tx_flow=1 and no pause outstanding, a fill level of XOFF_LEVEL (12 of 16) or more raises ins_req with ins_xoff=1 and ins_char=cfg_xoff_char in the next cycle. The request is held until ins_taken. With cfg_auto_tx_flow=0 no request is raised.
- R10: After a pause has been taken, no further pause request is made. When the fill level is XON_LEVEL (4) or less, ins_req rises with ins_xoff=0 and ins_char=cfg_xon_char. Only after that resume is taken can a new pause request be made.
- R11: tx_normal_ok is 0 whenever ins_req is 1 or tx_enable is 0. Otherwise it is 1.
- R12: In multidrop mode, flow characters have no effect while the gate is closed, and address characters are never treated as flow characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | DW | Received character |
| rx_addr_bit | input | 1 | Address flag received in the parity-bit position |
| fill_level | input | LW | Receive FIFO occupancy, 0 to DEPTH |
| ins_taken | input | 1 | Transmitter has sent the requested flow character |
| cfg_auto_rx_flow | input | 1 | Act on received pause/resume characters |
| cfg_auto_tx_flow | input | 1 | Request pause/resume from the fill level |
| cfg_multidrop | input | 1 | Address-gated reception |
| cfg_xon_char | input | DW | Resume character |
| cfg_xoff_char | input | DW | Pause character |
| cfg_chan_addr | input | DW | Station address |
| cfg_gp_chars | input | NGP*DW | General-purpose match characters, field i at bits DW*i+DW-1:DW*i |
| tx_enable | output | 1 | Local transmitter allowed to run |
| tx_normal_ok | output | 1 | Transmitter may send its next normal character |
| ins_req | output | 1 | Request to insert a flow character |
| ins_xoff | output | 1 | Kind of request: 1 pause, 0 resume |
| ins_char | output | DW | Character to insert |
| rx_write | output | 1 | Write the character to the receive FIFO |
| gp_hit | output | NGP | Per general-purpose character match pulse |

## Verification
The bench uses the default parameters: 8-bit characters, three general-purpose comparators, a 16-entry FIFO, and thresholds of 12 and 4. With 8-bit characters, all 256 character values can be sent in each of the plain, flow-off and multidrop setups, so every comparator result and gate decision is tried. With a 16-entry FIFO, the fill level can be ramped through every value up and back down, which covers both threshold crossings, the hold-until-taken behaviour and the re-arming of the pause request.

// File: rtl/rxflow_pkg.sv
package rxflow_pkg;
  typedef enum logic {KIND_XON = 1'b0, KIND_XOFF = 1'b1} ins_kind_e;

  function automatic logic level_at_or_above(input int unsigned lvl, input int unsigned thr);
    return lvl >= thr;
  endfunction

  function automatic logic level_at_or_below(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction
endpackage

// File: rtl/rxflow_cmp.sv
module rxflow_cmp #(
  parameter int DW  = 8,
  parameter int NGP = 3
) (
  input  logic [DW-1:0]     data,
  input  logic [DW-1:0]     xon_char,
  input  logic [DW-1:0]     xoff_char,
  input  logic [DW-1:0]     addr_char,
  input  logic [NGP*DW-1:0] gp_chars,
  output logic              hit_xon,
  output logic              hit_xoff,
  output logic              hit_addr,
  output logic [NGP-1:0]    hit_gp
);
  assign hit_xon  = (data == xon_char);
  assign hit_xoff = (data == xoff_char);
  assign hit_addr = (data == addr_char);

  for (genvar i = 0; i < NGP; i++) begin : g_gp
    assign hit_gp[i] = (data == gp_chars[i*DW +: DW]);
  end
endmodule

// File: rtl/rxflow_rxpath.sv
module rxflow_rxpath #(
  parameter int NGP = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_valid,
  input  logic           rx_addr_bit,
  input  logic           cfg_auto_rx_flow,
  input  logic           cfg_multidrop,
  input  logic           hit_xon,
  input  logic           hit_xoff,
  input  logic           hit_addr,
  input  logic [NGP-1:0] hit_gp,
  output logic           rx_write,
  output logic [NGP-1:0] gp_hit,
  output logic           halted,
  output logic           awake,
  output logic           flow_consume
);
  logic is_addr, gate_open, flow_hit;

  always_comb begin
    is_addr      = cfg_multidrop && rx_addr_bit;
    gate_open    = !cfg_multidrop || awake;
    flow_hit     = cfg_auto_rx_flow && !is_addr && gate_open && (hit_xon || hit_xoff);
    flow_consume = rx_valid && flow_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_write <= 1'b0;
      gp_hit   <= '0;
      halted   <= 1'b0;
      awake    <= 1'b0;
    end else begin
      rx_write <= rx_valid && (is_addr ? hit_addr : (gate_open && !flow_hit));
      gp_hit   <= rx_valid ? hit_gp : '0;
      if (!cfg_multidrop)          awake <= 1'b0;
      else if (rx_valid && is_addr) awake <= hit_addr;
      if (!cfg_auto_rx_flow)       halted <= 1'b0;
      else if (flow_consume)       halted <= hit_xoff;
    end
  end
endmodule

// File: rtl/rxflow_fillreq.sv
module rxflow_fillreq
  import rxflow_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int XOFF_LEVEL = 12,
  parameter int XON_LEVEL  = 4,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] fill_level,
  input  logic          cfg_auto_tx_flow,
  input  logic          ins_taken,
  output logic          ins_req,
  output logic          ins_xoff,
  output logic          xoff_out
);
  ins_kind_e kind;
  logic want_xoff, want_xon;

  always_comb begin
    want_xoff = !xoff_out && level_at_or_above(int'(fill_level), XOFF_LEVEL);
    want_xon  = xoff_out && level_at_or_below(int'(fill_level), XON_LEVEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_req  <= 1'b0;
      kind     <= KIND_XON;
      xoff_out <= 1'b0;
    end else if (!cfg_auto_tx_flow) begin
      ins_req  <= 1'b0;
      xoff_out <= 1'b0;
    end else if (ins_req) begin
      if (ins_taken) begin
        ins_req  <= 1'b0;
        xoff_out <= (kind == KIND_XOFF);
      end
    end else if (want_xoff) begin
      ins_req <= 1'b1;
      kind    <= KIND_XOFF;
    end else if (want_xon) begin
      ins_req <= 1'b1;
      kind    <= KIND_XON;
    end
  end

  assign ins_xoff = (kind == KIND_XOFF);
endmodule

// File: rtl/rxflow_ctl.sv
module rxflow_ctl #(
  parameter int DW         = 8,
  parameter int NGP        = 3,
  parameter int DEPTH      = 16,
  parameter int XOFF_LEVEL = 12,
  parameter int XON_LEVEL  = 4,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_addr_bit,
  input  logic [LW-1:0]     fill_level,
  input  logic              ins_taken,
  input  logic              cfg_auto_rx_flow,
  input  logic              cfg_auto_tx_flow,
  input  logic              cfg_multidrop,
  input  logic [DW-1:0]     cfg_xon_char,
  input  logic [DW-1:0]     cfg_xoff_char,
  input  logic [DW-1:0]     cfg_chan_addr,
  input  logic [NGP*DW-1:0] cfg_gp_chars,
  output logic              tx_enable,
  output logic              tx_normal_ok,
  output logic              ins_req,
  output logic              ins_xoff,
  output logic [DW-1:0]     ins_char,
  output logic              rx_write,
  output logic [NGP-1:0]    gp_hit
);
  logic           hit_xon, hit_xoff, hit_addr;
  logic [NGP-1:0] hit_gp;
  logic           halted, awake, flow_consume, xoff_out;

  rxflow_cmp #(.DW(DW), .NGP(NGP)) u_cmp (
    .data(rx_data), .xon_char(cfg_xon_char), .xoff_char(cfg_xoff_char),
    .addr_char(cfg_chan_addr), .gp_chars(cfg_gp_chars),
    .hit_xon(hit_xon), .hit_xoff(hit_xoff), .hit_addr(hit_addr), .hit_gp(hit_gp)
  );

  rxflow_rxpath #(.NGP(NGP)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_addr_bit(rx_addr_bit),
    .cfg_auto_rx_flow(cfg_auto_rx_flow), .cfg_multidrop(cfg_multidrop),
    .hit_xon(hit_xon), .hit_xoff(hit_xoff), .hit_addr(hit_addr), .hit_gp(hit_gp),
    .rx_write(rx_write), .gp_hit(gp_hit), .halted(halted), .awake(awake),
    .flow_consume(flow_consume)
  );

  rxflow_fillreq #(.DEPTH(DEPTH), .XOFF_LEVEL(XOFF_LEVEL), .XON_LEVEL(XON_LEVEL)) u_fill (
    .clk(clk), .rst_n(rst_n), .fill_level(fill_level),
    .cfg_auto_tx_flow(cfg_auto_tx_flow), .ins_taken(ins_taken),
    .ins_req(ins_req), .ins_xoff(ins_xoff), .xoff_out(xoff_out)
  );

  assign tx_enable    = !halted;
  assign tx_normal_ok = tx_enable && !ins_req;
  assign ins_char     = ins_xoff ? cfg_xoff_char : cfg_xon_char;
endmodule

// File: rtl/rxflow_ctl_chk.sv
module rxflow_ctl_chk #(
  parameter int DW  = 8,
  parameter int NGP = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic [DW-1:0]     rx_data,
  input logic              rx_addr_bit,
  input logic              ins_taken,
  input logic              cfg_auto_rx_flow,
  input logic              cfg_auto_tx_flow,
  input logic              cfg_multidrop,
  input logic [DW-1:0]     cfg_xon_char,
  input logic [DW-1:0]     cfg_xoff_char,
  input logic [NGP*DW-1:0] cfg_gp_chars,
  input logic              tx_enable,
  input logic              tx_normal_ok,
  input logic              ins_req,
  input logic              ins_xoff,
  input logic              rx_write,
  input logic [NGP-1:0]    gp_hit,
  input logic              awake,
  input logic              xoff_out
);
  p_xoff_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_auto_rx_flow && !cfg_multidrop && rx_data == cfg_xoff_char)
    |=> (!tx_enable && !rx_write));

  p_xon_resumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_auto_rx_flow && !cfg_multidrop && rx_data == cfg_xon_char
     && rx_data != cfg_xoff_char) |=> (tx_enable && !rx_write));

  p_flow_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_auto_rx_flow |=> tx_enable);

  p_sleep_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multidrop && !awake && rx_valid && !rx_addr_bit) |=> !rx_write);

  for (genvar i = 0; i < NGP; i++) begin : g_gp
    p_gp_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_data == cfg_gp_chars[i*DW +: DW]) |=> gp_hit[i]);
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_taken && cfg_auto_tx_flow) |=> (ins_req && $stable(ins_xoff)));

  p_xon_needs_xoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_xoff) |-> xoff_out);

  p_req_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req |-> !tx_normal_ok);

  p_addr_not_flow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multidrop && cfg_auto_rx_flow && rx_valid && rx_addr_bit)
    |=> (tx_enable == $past(tx_enable)));
endmodule

bind rxflow_ctl rxflow_ctl_chk #(.DW(DW), .NGP(NGP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_addr_bit(rx_addr_bit), .ins_taken(ins_taken),
  .cfg_auto_rx_flow(cfg_auto_rx_flow), .cfg_auto_tx_flow(cfg_auto_tx_flow),
  .cfg_multidrop(cfg_multidrop), .cfg_xon_char(cfg_xon_char),
  .cfg_xoff_char(cfg_xoff_char), .cfg_gp_chars(cfg_gp_chars),
  .tx_enable(tx_enable), .tx_normal_ok(tx_normal_ok), .ins_req(ins_req),
  .ins_xoff(ins_xoff), .rx_write(rx_write), .gp_hit(gp_hit),
  .awake(awake), .xoff_out(xoff_out)
);

// File: tb/rxflow_ctl_test.sv
module rxflow_ctl_test;
  localparam int DW = 8, NGP = 3, DEPTH = 16, XOFF_LV = 12, XON_LV = 4;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [7:0] XON = 8'h11, XOFF = 8'h13, ADDR = 8'h5A;
  localparam logic [7:0] GP0 = 8'h41, GP1 = 8'h42, GP2 = 8'h13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_addr_bit = 1'b0, ins_taken = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic [LW-1:0] fill_level = '0;
  logic cfg_auto_rx_flow = 1'b0, cfg_auto_tx_flow = 1'b0, cfg_multidrop = 1'b0;
  logic tx_enable, tx_normal_ok, ins_req, ins_xoff, rx_write;
  logic [DW-1:0] ins_char;
  logic [NGP-1:0] gp_hit;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rxflow_ctl uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_addr_bit(rx_addr_bit), .fill_level(fill_level), .ins_taken(ins_taken),
    .cfg_auto_rx_flow(cfg_auto_rx_flow), .cfg_auto_tx_flow(cfg_auto_tx_flow),
    .cfg_multidrop(cfg_multidrop), .cfg_xon_char(XON), .cfg_xoff_char(XOFF),
    .cfg_chan_addr(ADDR), .cfg_gp_chars({GP2, GP1, GP0}),
    .tx_enable(tx_enable), .tx_normal_ok(tx_normal_ok), .ins_req(ins_req),
    .ins_xoff(ins_xoff), .ins_char(ins_char), .rx_write(rx_write), .gp_hit(gp_hit)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic ab);
    rx_data = d; rx_addr_bit = ab; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic int gp_exp(input logic [7:0] c);
    return ((c == GP2) ? 4 : 0) + ((c == GP1) ? 2 : 0) + ((c == GP0) ? 1 : 0);
  endfunction

  task automatic take();
    ins_taken = 1'b1;
    @(negedge clk);
    ins_taken = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic halted_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_enable", tx_enable, 1);
    chk("R1 tx_normal_ok", tx_normal_ok, 1);
    chk("R1 ins_req", ins_req, 0);
    chk("R1 rx_write", rx_write, 0);
    chk("R1 gp_hit", gp_hit, 0);

    // R2 R3 R5 R8: all characters, automatic receive flow, no multidrop
    cfg_auto_rx_flow = 1'b1;
    @(negedge clk);
    halted_m = 1'b0;
    for (int c = 0; c < 256; c++) begin
      logic [7:0] ch;
      ch = 8'(c);
      send(ch, ch[0]);
      if (ch == XOFF) halted_m = 1'b1;
      if (ch == XON)  halted_m = 1'b0;
      chk("R5 R2 R3 rx_write", rx_write, (ch == XON || ch == XOFF) ? 0 : 1);
      chk("R2 R3 tx_enable", tx_enable, halted_m ? 0 : 1);
      chk("R8 gp_hit", gp_hit, gp_exp(ch));
    end
    send(XON, 1'b0);
    chk("R3 resume", tx_enable, 1);
    chk("R3 consumed", rx_write, 0);

    // R4: flow handling off
    send(XOFF, 1'b0);
    chk("R2 halt before R4", tx_enable, 0);
    cfg_auto_rx_flow = 1'b0;
    @(negedge clk);
    chk("R4 enable when off", tx_enable, 1);
    for (int c = 0; c < 256; c++) begin
      send(8'(c), 1'b0);
      chk("R4 rx_write", rx_write, 1);
      chk("R4 tx_enable", tx_enable, 1);
    end

    // R6 R7 R12: multidrop
    cfg_auto_rx_flow = 1'b1;
    cfg_multidrop = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 256; c++) begin
      send(8'(c), 1'b0);
      chk("R7 asleep drop", rx_write, 0);
      chk("R12 asleep flow ignored", tx_enable, 1);
      chk("R8 gp while asleep", gp_hit, gp_exp(8'(c)));
    end
    send(ADDR, 1'b1);
    chk("R6 address written", rx_write, 1);
    send(XOFF, 1'b0);
    chk("R2 awake halt", tx_enable, 0);
    chk("R2 awake consumed", rx_write, 0);
    send(XON, 1'b1);
    chk("R7 other address dropped", rx_write, 0);
    chk("R12 address not flow", tx_enable, 0);
    send(8'h22, 1'b0);
    chk("R7 dropped after sleep", rx_write, 0);
    send(XON, 1'b0);
    chk("R12 resume ignored asleep", tx_enable, 0);
    send(ADDR, 1'b1);
    chk("R6 rewake", rx_write, 1);
    send(XON, 1'b0);
    chk("R3 awake resume", tx_enable, 1);
    send(8'h22, 1'b0);
    chk("R6 data written", rx_write, 1);
    cfg_multidrop = 1'b0;

    // R9 R10 R11: fill-level requests
    cfg_auto_tx_flow = 1'b1;
    for (int f = 0; f <= DEPTH; f++) begin
      fill_level = LW'(f);
      @(negedge clk);
      chk("R9 pause request", ins_req, (f >= XOFF_LV) ? 1 : 0);
      chk("R11 normal blocked", tx_normal_ok, (f >= XOFF_LV) ? 0 : 1);
      if (f >= XOFF_LV) begin
        chk("R9 kind", ins_xoff, 1);
        chk("R9 char", ins_char, XOFF);
      end
    end
    take();
    chk("R9 cleared on take", ins_req, 0);
    @(negedge clk);
    chk("R10 once per crossing", ins_req, 0);
    for (int f = DEPTH; f >= 0; f--) begin
      fill_level = LW'(f);
      @(negedge clk);
      chk("R10 resume request", ins_req, (f <= XON_LV) ? 1 : 0);
      if (f <= XON_LV) begin
        chk("R10 kind", ins_xoff, 0);
        chk("R10 char", ins_char, XON);
        chk("R11 normal blocked", tx_normal_ok, 0);
      end
    end
    take();
    fill_level = LW'(3);
    @(negedge clk);
    chk("R10 no repeat resume", ins_req, 0);
    chk("R11 normal allowed", tx_normal_ok, 1);
    fill_level = LW'(XOFF_LV);
    @(negedge clk);
    chk("R10 rearmed pause", ins_req, 1);
    chk("R10 rearmed kind", ins_xoff, 1);
    take();
    cfg_auto_tx_flow = 1'b0;
    fill_level = LW'(0);
    @(negedge clk);
    chk("R9 off no request", ins_req, 0);
    fill_level = LW'(DEPTH);
    @(negedge clk);
    chk("R9 off at full", ins_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule